// File: doc/BRIEF.md
# Dual-Pin Edge-Triggered Input Capture

This block holds a set of independent capture channels that timestamp external events against a free-running 16-bit timebase supplied from outside. Each channel watches two trigger pins. Both pins pass through a synchroniser and are then ORed into one merged trigger. When the merged trigger makes a transition that the channel's edge mode accepts, the channel copies the timebase into its capture register and sets its capture flag. The flag drives the channel's interrupt request whenever the request is enabled.

The edge mode is a 2-bit field for each channel. It selects off, rising, falling or both edges. Neither pin can be masked on its own: the only way to silence a channel is to turn it off, and that silences both pins. Software reads the captured value and clears the flag with a one-cycle clear pulse. The channels share nothing except the timebase, so activity on one channel never disturbs another.

Each channel contains two small state machines. The trigger tracker has the states TRG_LOW and TRG_HIGH. It moves LOW to HIGH when the merged trigger goes high, which is a rise, and HIGH to LOW when the merged trigger goes low, which is a fall. A move fires a capture only when the mode permits that direction. The flag machine has the states FLG_IDLE and FLG_PEND. It moves IDLE to PEND on a capture (set). It moves PEND to IDLE on a clear pulse, but only in a cycle with no capture (clear).

Top module: `cap_unit`

## Requirements
- R1: After reset, every capture register reads 0, and every flag and every interrupt request is low.
- R2: Edge field value 01 selects rising edges. A low-to-high move of the merged trigger captures, and a high-to-low move does not.
- R3: Edge field value 10 selects falling edges. A high-to-low move of the merged trigger captures, and a low-to-high move does not.
- R4: Edge field value 11 captures on both directions of the merged trigger.
- R5: Edge field value 00 disables the channel. Pin activity then leaves the capture register and the flag unchanged.
- R6: The merged trigger is the OR of the channel's two pins, so either pin can fire a capture. A pin that moves while the other pin is high causes no capture.
- R7: A pin change applied before clock edge E1 is captured at edge E3. The register takes the timebase present at E3, and the flag goes high at that same edge and not earlier.
- R8: The flag stays set until a clear pulse. A new capture while the flag is set overwrites the register and keeps the flag set. A capture and a clear in the same cycle leave the flag set.
- R9: A channel's interrupt request equals its flag ANDed with its enable, in the same cycle.
- R10: Channels are independent. Edges on one channel change neither the register nor the flag of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timebase | input | TB_W (16) | Free-running count that is sampled on capture |
| trig_a | input | NUM_CH | First trigger pin of each channel |
| trig_b | input | NUM_CH | Second trigger pin of each channel |
| edge_sel | input | 2*NUM_CH | Edge mode per channel: 00 off, 01 rise, 10 fall, 11 both |
| irq_en | input | NUM_CH | Interrupt enable per channel |
| flag_clr | input | NUM_CH | One-cycle flag clear per channel |
| cap_value | output | TB_W*NUM_CH | Capture registers; channel i at bits [16*i +: 16] |
| cap_flag | output | NUM_CH | Capture flags |
| irq | output | NUM_CH | Interrupt requests |

## Verification
A pin change driven before edge E1 passes two synchroniser flops and the trigger tracker, so the capture register and the flag change at edge E3. The bench drives a different timebase value in each of those cycles. It checks the flag just before E3, where it must still hold its old value, and checks the register and the flag just after E3, where the register must hold the value driven for E3. A flag clear takes effect at the next edge. The interrupt request follows the flag and its enable in the same cycle, so those checks sample one half-cycle after the change is applied.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic {
        TRG_LOW  = 1'b0,
        TRG_HIGH = 1'b1
    } trg_state_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_in,
    input  edge_mode_e mode,
    output logic       fire
);
    trg_state_e state_q, state_d;
    logic rise_ok, fall_ok;

    // Decode which directions the mode accepts.
    always_comb begin
        rise_ok = 1'b0;
        fall_ok = 1'b0;
        unique case (mode)
            EDGE_OFF:  ;
            EDGE_RISE: rise_ok = 1'b1;
            EDGE_FALL: fall_ok = 1'b1;
            EDGE_BOTH: begin
                rise_ok = 1'b1;
                fall_ok = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            TRG_LOW: if (level_in) begin
                state_d = TRG_HIGH;
                fire    = rise_ok;
            end
            TRG_HIGH: if (!level_in) begin
                state_d = TRG_LOW;
                fire    = fall_ok;
            end
            default: state_d = TRG_LOW;
        endcase
    end

    assert_fire_on_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q != $past(state_q)));
    assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !fire);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int TB_W      = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] timebase,
    input  logic            pin_a,
    input  logic            pin_b,
    input  edge_mode_e      mode,
    input  logic            irq_en,
    input  logic            flag_clr,
    output logic [TB_W-1:0] cap_value,
    output logic            flag,
    output logic            irq
);
    localparam int PINS = 2;

    logic [PINS-1:0] pins_sync;
    logic            merged;
    logic            hit;
    logic [TB_W-1:0] cap_q;
    flag_state_e     fstate_q, fstate_d;

    cap_sync #(.WIDTH(PINS), .STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_b, pin_a}),
        .dout (pins_sync)
    );

    assign merged = |pins_sync;

    cap_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_in(merged),
        .mode    (mode),
        .fire    (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cap_q <= '0;
        else if (hit) cap_q <= timebase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fstate_q <= FLG_IDLE;
        else        fstate_q <= fstate_d;
    end

    always_comb begin
        fstate_d = fstate_q;
        unique case (fstate_q)
            FLG_IDLE: if (hit) fstate_d = FLG_PEND;
            FLG_PEND: if (flag_clr && !hit) fstate_d = FLG_IDLE;
            default:  fstate_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        cap_value = cap_q;
        flag      = (fstate_q == FLG_PEND);
        irq       = flag && irq_en;
    end

    assert_capture_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag);
    assert_reg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_q));
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int TB_W   = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TB_W-1:0]        timebase,
    input  logic [NUM_CH-1:0]      trig_a,
    input  logic [NUM_CH-1:0]      trig_b,
    input  logic [2*NUM_CH-1:0]    edge_sel,
    input  logic [NUM_CH-1:0]      irq_en,
    input  logic [NUM_CH-1:0]      flag_clr,
    output logic [TB_W*NUM_CH-1:0] cap_value,
    output logic [NUM_CH-1:0]      cap_flag,
    output logic [NUM_CH-1:0]      irq
);
    localparam int MODE_W = 2;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        edge_mode_e mode_ch;
        assign mode_ch = edge_mode_e'(edge_sel[MODE_W*ch +: MODE_W]);

        cap_channel #(.TB_W(TB_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .timebase (timebase),
            .pin_a    (trig_a[ch]),
            .pin_b    (trig_b[ch]),
            .mode     (mode_ch),
            .irq_en   (irq_en[ch]),
            .flag_clr (flag_clr[ch]),
            .cap_value(cap_value[TB_W*ch +: TB_W]),
            .flag     (cap_flag[ch]),
            .irq      (irq[ch])
        );
    end
endmodule

// File: tb/test_cap_unit.sv
module test_cap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timebase = '0;
    logic [1:0]  trig_a = '0, trig_b = '0;
    logic [3:0]  edge_sel = '0;
    logic [1:0]  irq_en = '0, flag_clr = '0;
    logic [31:0] cap_value;
    logic [1:0]  cap_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model [2] = '{16'h0, 16'h0};
    logic [15:0] base = 16'h1000;

    // {mode[1:0], use_pin_b, new_level, expect_capture}
    localparam logic [4:0] VEC [0:7] = '{
        5'b01_0_1_1, 5'b01_0_0_0, 5'b10_0_0_1, 5'b10_1_1_0,
        5'b11_1_1_1, 5'b11_1_0_1, 5'b00_0_1_0, 5'b01_1_1_1
    };

    cap_unit i_cap_unit (
        .clk(clk), .rst_n(rst_n), .timebase(timebase),
        .trig_a(trig_a), .trig_b(trig_b), .edge_sel(edge_sel),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(int ch, bit pinb, bit lvl);
        if (pinb) trig_b[ch] = lvl;
        else      trig_a[ch] = lvl;
    endtask

    task automatic pulse_clear(int ch);
        flag_clr[ch] = 1'b1;
        step();
        flag_clr[ch] = 1'b0;
    endtask

    // Called just after a falling clock edge.
    task automatic drive_edge(int ch, bit pinb, bit lvl, bit expc, string req);
        logic pre;
        pre = cap_flag[ch];
        base += 16;
        set_pin(ch, pinb, lvl); timebase = base;
        step(); timebase = base + 1;
        step(); timebase = base + 2;
        chk("R7", "flag before third edge", cap_flag[ch], pre);
        step(); timebase = base + 3;
        if (expc) model[ch] = base + 2;
        chk(req, "flag", cap_flag[ch], pre | expc);
        chk(req, "value", cap_value[16*ch +: 16], model[ch]);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk("R1", "values", cap_value, 32'h0);
        chk("R1", "flags", cap_flag, 2'b00);
        chk("R1", "irq", irq, 2'b00);

        // Table walk on channel 0 (R2, R3, R4, R5, R6 pin b)
        foreach (VEC[i]) begin
            logic [4:0] v;
            v = VEC[i];
            edge_sel[1:0] = 2'b00;
            trig_a[0] = 1'b0; trig_b[0] = 1'b0;
            set_pin(0, v[2], ~v[1]);
            step(4);
            pulse_clear(0);
            edge_sel[1:0] = v[4:3];
            case (v[4:3])
                2'b01: drive_edge(0, v[2], v[1], v[0], "R2");
                2'b10: drive_edge(0, v[2], v[1], v[0], "R3");
                2'b11: drive_edge(0, v[2], v[1], v[0], "R4");
                default: drive_edge(0, v[2], v[1], v[0], "R5");
            endcase
        end

        // R6: OR merge, a pin moving while the other is high causes no capture
        edge_sel[1:0] = 2'b00;
        trig_a[0] = 1'b1; trig_b[0] = 1'b0;
        step(4);
        pulse_clear(0);
        edge_sel[1:0] = 2'b01;
        drive_edge(0, 1, 1, 0, "R6");
        drive_edge(0, 0, 0, 0, "R6");
        drive_edge(0, 1, 0, 0, "R6");
        drive_edge(0, 0, 1, 1, "R6");

        // R8: second capture with flag set overwrites value, flag stays
        drive_edge(0, 0, 0, 0, "R8");
        drive_edge(0, 0, 1, 1, "R8");

        // R9: interrupt gating
        irq_en[0] = 1'b0;
        step();
        chk("R9", "irq disabled", irq[0], 1'b0);
        irq_en[0] = 1'b1;
        #1;
        chk("R9", "irq enabled", irq[0], 1'b1);
        step();
        pulse_clear(0);
        chk("R8", "flag after clear", cap_flag[0], 1'b0);
        chk("R9", "irq after clear", irq[0], 1'b0);

        // R8: clear in the same cycle as a capture leaves the flag set
        drive_edge(0, 0, 0, 0, "R8");
        base += 16;
        trig_a[0] = 1'b1; timebase = base;
        step(); timebase = base + 1;
        step(); timebase = base + 2; flag_clr[0] = 1'b1;
        step(); timebase = base + 3; flag_clr[0] = 1'b0;
        model[0] = base + 2;
        chk("R8", "flag on clear collision", cap_flag[0], 1'b1);
        chk("R8", "value on clear collision", cap_value[15:0], model[0]);

        // R10: channel 1 activity leaves channel 0 alone
        edge_sel[3:2] = 2'b11;
        irq_en[1] = 1'b1;
        drive_edge(1, 0, 1, 1, "R10");
        chk("R10", "ch0 value", cap_value[15:0], model[0]);
        chk("R10", "ch0 flag", cap_flag[0], 1'b1);
        chk("R10", "ch1 irq", irq[1], 1'b1);
        pulse_clear(0);
        drive_edge(1, 1, 1, 0, "R10");
        chk("R10", "ch0 flag stays clear", cap_flag[0], 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule